// File: doc/BRIEF.md
# Resolver Excitation Phase Alignment Loop

This block keeps a resolver's excitation carrier in step with a converter that samples continuously and cannot be retimed. The converter sends sine and cosine samples in 32-sample frames, one frame per carrier period. A strobe marks the end of each 16-sample half. Alignment comes only from delaying the excitation. The block measures how far the frame's zero crossings sit from frame positions 0 and 16. A slow integral-only loop then moves a delay accumulator until those two samples read zero.

The accumulator starts from a value loaded at reset. A quarter or half of the period is a sensible choice, and it fixes which of the two lock points the loop settles into. The block drives a table phase index to an external sine table. The index advances one step per converter sample, offset by the integer part of the delay. A settled flag with hysteresis reports when the loop has locked.

Top module: `rxa_align_top`

## Requirements
- R1: While `rst` is high, `dly_acc` loads `start_dly` and `settled` is 0. The cycle after release, `phase_idx` equals `start_dly[15:11]`.
- R2: A frame's error is the sample at position 0 minus the sample at position 16, taken from the channel whose position-8 sample has the larger magnitude. Sine wins a tie.
- R3: The accumulator updates only on a clock where `half_rdy` is 1 and `half_sel` is 1 (second half). A strobe with `half_sel` = 0 leaves `dly_acc` and `settled` unchanged.
- R4: On an update, `dly_acc` becomes `dly_acc` plus the error arithmetically shifted right by the gain. The sum is taken modulo 2^16, so the delay wraps around one carrier period.
- R5: The gain shift is `gain_sh` clamped to the range 4 to 12. A value below 4 acts as 4, and a value above 12 acts as 12.
- R6: `settled` rises on the update that completes 8 consecutive frames with |error| < `settle_thr`, and not before.
- R7: A frame with |error| > 2·`settle_thr` clears `settled` and the frame count. A frame between those bounds (inclusive) clears the count but leaves `settled` as it was.
- R8: Sample position counts valid samples modulo 32 from reset. One clock later, `phase_idx` = (position + `dly_acc[15:11]`) mod 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_dly | input | 16 | Delay loaded at reset (fixed point, 2^16 = one period) |
| gain_sh | input | 4 | Integral gain as a right shift |
| settle_thr | input | 12 | Lock threshold on absolute error |
| smp_vld | input | 1 | One converter sample pair present |
| smp_sin | input | 12 | Signed sine-channel sample |
| smp_cos | input | 12 | Signed cosine-channel sample |
| half_rdy | input | 1 | Half-buffer complete strobe |
| half_sel | input | 1 | 1 when the strobe closes the second half |
| dly_acc | output | 16 | Excitation delay accumulator |
| phase_idx | output | 5 | Sine table index for the excitation |
| settled | output | 1 | Loop locked |

## Verification
A corrupted accumulator shows on `dly_acc` right after the next second-half strobe. Its integer part reaches `phase_idx` one clock later. A wrong channel choice or a wrong shift gives an accumulator step that differs from an arithmetic model, so it is visible on the first frame with that input pattern. A broken frame counter or broken hysteresis shows up as `settled` changing one frame early or late, or on a boundary error value of exactly the threshold or exactly twice it. A slipped position counter offsets `phase_idx` as soon as a partial frame leaves the stream idle.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  localparam int unsigned GAIN_LO = 4;
  localparam int unsigned GAIN_HI = 12;
  typedef enum logic {CH_SIN = 1'b0, CH_COS = 1'b1} chan_e;
endpackage

// File: rtl/rxa_capture.sv
// Counts sample positions in the frame and latches each channel at the
// two zero-crossing positions and at the quarter-frame peak position.
module rxa_capture #(
  parameter int SMP_W     = 12,
  parameter int FRAME_LEN = 32,
  parameter int POS_W     = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_vld,
  input  logic [1:0][SMP_W-1:0]   smp_in,
  output logic [POS_W-1:0]        pos,
  output logic [1:0][SMP_W-1:0]   at_z0,
  output logic [1:0][SMP_W-1:0]   at_pk,
  output logic [1:0][SMP_W-1:0]   at_z1
);
  localparam logic [POS_W-1:0] P_Z0   = '0;
  localparam logic [POS_W-1:0] P_PK   = POS_W'(FRAME_LEN / 4);
  localparam logic [POS_W-1:0] P_Z1   = POS_W'(FRAME_LEN / 2);
  localparam logic [POS_W-1:0] P_LAST = POS_W'(FRAME_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (smp_vld) begin
      pos <= (pos == P_LAST) ? '0 : pos + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      at_z0 <= '0;
      at_pk <= '0;
      at_z1 <= '0;
    end else if (smp_vld) begin
      for (int ch = 0; ch < 2; ch++) begin
        if (pos == P_Z0) at_z0[ch] <= smp_in[ch];
        if (pos == P_PK) at_pk[ch] <= smp_in[ch];
        if (pos == P_Z1) at_z1[ch] <= smp_in[ch];
      end
    end
  end
endmodule

// File: rtl/rxa_err.sv
// Picks the channel with the stronger envelope and forms its zero-crossing error.
module rxa_err
  import rxa_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input  logic [1:0][SMP_W-1:0] at_z0,
  input  logic [1:0][SMP_W-1:0] at_pk,
  input  logic [1:0][SMP_W-1:0] at_z1,
  output chan_e                 sel,
  output logic signed [SMP_W:0] err,
  output logic [SMP_W:0]        err_mag
);
  function automatic logic [SMP_W:0] mag(input logic [SMP_W-1:0] v);
    logic [SMP_W:0] x;
    x = {v[SMP_W-1], v};
    return x[SMP_W] ? (~x + 1'b1) : x;
  endfunction

  logic signed [SMP_W:0] diff [2];

  for (genvar ch = 0; ch < 2; ch++) begin : g_diff
    assign diff[ch] = $signed({at_z0[ch][SMP_W-1], at_z0[ch]})
                    - $signed({at_z1[ch][SMP_W-1], at_z1[ch]});
  end

  always_comb begin
    sel     = (mag(at_pk[1]) > mag(at_pk[0])) ? CH_COS : CH_SIN;
    err     = (sel == CH_COS) ? diff[1] : diff[0];
    err_mag = err[SMP_W] ? (~err + 1'b1) : err;
  end
endmodule

// File: rtl/rxa_integ.sv
// Integral-only delay accumulator, wrapping modulo one carrier period.
module rxa_integ
  import rxa_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int ACC_W = 16,
  parameter int GSH_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  upd,
  input  logic [ACC_W-1:0]      start_dly,
  input  logic [GSH_W-1:0]      gain_sh,
  input  logic signed [SMP_W:0] err,
  output logic [ACC_W-1:0]      acc
);
  localparam logic [GSH_W-1:0] SH_LO = GSH_W'(GAIN_LO);
  localparam logic [GSH_W-1:0] SH_HI = GSH_W'(GAIN_HI);

  logic [GSH_W-1:0]        sh;
  logic signed [ACC_W-1:0] err_x;
  logic signed [ACC_W-1:0] step;

  always_comb begin
    if (gain_sh < SH_LO)      sh = SH_LO;
    else if (gain_sh > SH_HI) sh = SH_HI;
    else                      sh = gain_sh;
    err_x = {{(ACC_W-SMP_W-1){err[SMP_W]}}, err};
    step  = err_x >>> sh;
  end

  always_ff @(posedge clk) begin
    if (rst)      acc <= start_dly;
    else if (upd) acc <= acc + $unsigned(step);
  end
endmodule

// File: rtl/rxa_settle.sv
// Lock detector with hysteresis: N quiet frames to set, one loud frame to clear.
module rxa_settle #(
  parameter int SMP_W    = 12,
  parameter int SETTLE_N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [SMP_W:0]   err_mag,
  input  logic [SMP_W-1:0] thr,
  output logic             settled
);
  localparam int CNT_W = $clog2(SETTLE_N + 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(SETTLE_N);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_N - 1);

  logic [CNT_W-1:0] cnt;
  logic             quiet, loud;

  always_comb begin
    quiet = err_mag < {1'b0, thr};
    loud  = err_mag > {thr, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      settled <= 1'b0;
    end else if (upd) begin
      if (quiet) begin
        if (cnt != CNT_TOP)  cnt <= cnt + 1'b1;
        if (cnt >= CNT_LAST) settled <= 1'b1;
      end else if (loud) begin
        cnt     <= '0;
        settled <= 1'b0;
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/rxa_align_top.sv
module rxa_align_top
  import rxa_pkg::*;
#(
  parameter int SMP_W     = 12,
  parameter int ACC_W     = 16,
  parameter int FRAME_LEN = 32,
  parameter int GSH_W     = 4,
  parameter int SETTLE_N  = 8,
  localparam int POS_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] start_dly,
  input  logic [GSH_W-1:0] gain_sh,
  input  logic [SMP_W-1:0] settle_thr,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp_sin,
  input  logic [SMP_W-1:0] smp_cos,
  input  logic             half_rdy,
  input  logic             half_sel,
  output logic [ACC_W-1:0] dly_acc,
  output logic [POS_W-1:0] phase_idx,
  output logic             settled
);
  logic [1:0][SMP_W-1:0] smp_pair;
  logic [1:0][SMP_W-1:0] at_z0, at_pk, at_z1;
  logic [POS_W-1:0]      pos;
  chan_e                 sel;
  logic signed [SMP_W:0] err;
  logic [SMP_W:0]        err_mag;
  logic                  upd;

  assign smp_pair = {smp_cos, smp_sin};
  assign upd      = half_rdy & half_sel;

  rxa_capture #(.SMP_W(SMP_W), .FRAME_LEN(FRAME_LEN), .POS_W(POS_W)) u_cap (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_in(smp_pair),
    .pos(pos), .at_z0(at_z0), .at_pk(at_pk), .at_z1(at_z1)
  );

  rxa_err #(.SMP_W(SMP_W)) u_err (
    .at_z0(at_z0), .at_pk(at_pk), .at_z1(at_z1),
    .sel(sel), .err(err), .err_mag(err_mag)
  );

  rxa_integ #(.SMP_W(SMP_W), .ACC_W(ACC_W), .GSH_W(GSH_W)) u_int (
    .clk(clk), .rst(rst), .upd(upd), .start_dly(start_dly),
    .gain_sh(gain_sh), .err(err), .acc(dly_acc)
  );

  rxa_settle #(.SMP_W(SMP_W), .SETTLE_N(SETTLE_N)) u_set (
    .clk(clk), .rst(rst), .upd(upd), .err_mag(err_mag),
    .thr(settle_thr), .settled(settled)
  );

  always_ff @(posedge clk) begin
    if (rst) phase_idx <= start_dly[ACC_W-1 -: POS_W];
    else     phase_idx <= pos + dly_acc[ACC_W-1 -: POS_W];
  end
endmodule

// File: rtl/rxa_align_chk.sv
module rxa_align_chk #(
  parameter int SMP_W = 12,
  parameter int ACC_W = 16,
  parameter int POS_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             upd,
  input logic             smp_vld,
  input logic [SMP_W:0]   err_mag,
  input logic [SMP_W-1:0] settle_thr,
  input logic [ACC_W-1:0] dly_acc,
  input logic [POS_W-1:0] phase_idx,
  input logic             settled
);
  localparam int BND = 1 << (SMP_W - 4);

  logic [ACC_W-1:0]        acc_prev;
  logic signed [ACC_W-1:0] delta;

  always_ff @(posedge clk) acc_prev <= dly_acc;
  assign delta = $signed(dly_acc - acc_prev);

  p_acc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(dly_acc));

  p_step_bound_r5: assert property (@(posedge clk) disable iff (rst)
    upd |=> (delta <= BND) && (delta >= -BND));

  p_settle_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(settled) |-> $past(upd));

  p_settle_drop_r7: assert property (@(posedge clk) disable iff (rst)
    upd && (err_mag > {settle_thr, 1'b0}) |=> !settled);

  p_phase_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !smp_vld && !upd |=> ##1 $stable(phase_idx));
endmodule

bind rxa_align_top rxa_align_chk #(.SMP_W(SMP_W), .ACC_W(ACC_W), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst(rst), .upd(upd), .smp_vld(smp_vld), .err_mag(err_mag),
  .settle_thr(settle_thr), .dly_acc(dly_acc), .phase_idx(phase_idx),
  .settled(settled)
);

// File: tb/sim_rxa_align_top.sv
`timescale 1ns/1ps
module sim_rxa_align_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] start_dly = '0;
  logic [3:0]  gain_sh = 4'd4;
  logic [11:0] settle_thr = '0;
  logic        smp_vld = 1'b0;
  logic [11:0] smp_sin = '0, smp_cos = '0;
  logic        half_rdy = 1'b0, half_sel = 1'b0;
  logic [15:0] dly_acc;
  logic [4:0]  phase_idx;
  logic        settled;

  always #2.5 clk = ~clk;

  rxa_align_top u0 (
    .clk(clk), .rst(rst), .start_dly(start_dly), .gain_sh(gain_sh),
    .settle_thr(settle_thr), .smp_vld(smp_vld), .smp_sin(smp_sin),
    .smp_cos(smp_cos), .half_rdy(half_rdy), .half_sel(half_sel),
    .dly_acc(dly_acc), .phase_idx(phase_idx), .settled(settled)
  );

  int n_chk = 0, n_err = 0;
  int m_acc, m_cnt;
  bit m_set;

  function automatic int absv(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int start);
    rst = 1'b1; start_dly = 16'(start); smp_vld = 1'b0; half_rdy = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_acc = start; m_cnt = 0; m_set = 1'b0;
    @(negedge clk);
    chk("R1 acc", int'(dly_acc), start);
    chk("R1 settled", int'(settled), 0);
    chk("R1 phase", int'(phase_idx), (start >> 11) % 32);
  endtask

  task automatic frame(input int s0, input int s8, input int s16,
                       input int c0, input int c8, input int c16,
                       input bit second, input string req);
    int e, sh, g;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      smp_vld = 1'b1;
      smp_sin = 12'((i == 0) ? s0 : (i == 8) ? s8 : (i == 16) ? s16 : 3);
      smp_cos = 12'((i == 0) ? c0 : (i == 8) ? c8 : (i == 16) ? c16 : -5);
    end
    @(negedge clk);
    smp_vld = 1'b0; half_rdy = 1'b1; half_sel = second;
    @(negedge clk);
    half_rdy = 1'b0; half_sel = 1'b0;
    if (second) begin
      e  = (absv(c8) > absv(s8)) ? (c0 - c16) : (s0 - s16);
      g  = int'(gain_sh);
      sh = (g < 4) ? 4 : (g > 12) ? 12 : g;
      m_acc = (m_acc + (e >>> sh)) & 16'hFFFF;
      if (absv(e) < int'(settle_thr)) begin
        if (m_cnt < 8) m_cnt++;
        if (m_cnt >= 8) m_set = 1'b1;
      end else if (absv(e) > 2 * int'(settle_thr)) begin
        m_cnt = 0; m_set = 1'b0;
      end else begin
        m_cnt = 0;
      end
    end
    chk(req, int'(dly_acc), m_acc);
    chk({req, " settled"}, int'(settled), int'(m_set));
    @(negedge clk);
    chk("R8 phase", int'(phase_idx), (m_acc >> 11) % 32);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset(16'h4000);

    // R2: channel choice
    gain_sh = 4'd4;
    frame(200, 100, 0, -50, -300, 50, 1'b1, "R2 cos chosen");
    frame(160, 300, 0, 900, -300, -900, 1'b1, "R2 tie sine");
    frame(-400, 10, 400, 80, 20, 0, 1'b1, "R2 cos small");

    // R3: first-half strobe does nothing
    frame(1500, 600, -1500, 0, 0, 0, 1'b0, "R3 half0");

    // R4/R5: gain sweep with several error patterns
    for (int g = 0; g < 16; g++) begin
      gain_sh = 4'(g);
      for (int k = 0; k < 4; k++) begin
        int a, b;
        a = (k == 0) ? 1500 : (k == 1) ? -2000 : (k == 2) ? 37 : -5;
        b = (k == 0) ? -1200 : (k == 1) ? 2047 : (k == 2) ? 0 : 6;
        frame(a, 600, b, 800, (k % 2) ? 900 : 100, -300,
              1'b1, (g < 4 || g > 12) ? "R5 clamp" : "R4 step");
      end
    end

    // R4: wrap modulo one period
    do_reset(16'hFFF0);
    gain_sh = 4'd4;
    frame(800, 500, -800, 0, 0, 0, 1'b1, "R4 wrap");
    chk("R4 wrap value", int'(dly_acc), 84);

    // R6/R7: settle detection and hysteresis
    do_reset(16'h8000);
    gain_sh = 4'd12; settle_thr = 12'd50;
    for (int n = 0; n < 7; n++) frame(5, 500, -5, 0, 0, 0, 1'b1, "R6 before 8");
    chk("R6 not yet", int'(settled), 0);
    frame(5, 500, -5, 0, 0, 0, 1'b1, "R6 eighth");
    chk("R6 set", int'(settled), 1);
    frame(25, 500, -25, 0, 0, 0, 1'b1, "R7 equal thr");
    chk("R7 keep at thr", int'(settled), 1);
    frame(50, 500, -50, 0, 0, 0, 1'b1, "R7 equal 2thr");
    chk("R7 keep at 2thr", int'(settled), 1);
    frame(51, 500, -50, 0, 0, 0, 1'b1, "R7 above 2thr");
    chk("R7 cleared", int'(settled), 0);
    for (int n = 0; n < 7; n++) frame(-4, 500, 4, 0, 0, 0, 1'b1, "R6 recount");
    chk("R6 recount not yet", int'(settled), 0);
    frame(-4, 500, 4, 0, 0, 0, 1'b1, "R6 recount eighth");
    chk("R6 set again", int'(settled), 1);
    frame(900, 500, -900, 0, 0, 0, 1'b0, "R3 half0 keeps settled");

    // R8: partial frame offsets the table index
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); smp_vld = 1'b1;
    end
    @(negedge clk); smp_vld = 1'b0;
    @(negedge clk);
    chk("R8 partial", int'(phase_idx), (5 + (m_acc >> 11)) % 32);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule